// File: doc/BRIEF.md
# Banked GPIO controller with edge interrupts

This block drives and samples sixteen general-purpose pins arranged as two banks of eight. Software reaches it over a plain synchronous register port: an 8-bit address, an 8-bit write word with a write strobe, and a read strobe that returns a byte in the same cycle. Every pin owns two registers. The first holds its direction, its drive style, its pull setting and the level it drives. The second reports the pin's synchronized level and picks which transitions of that pin count as an interrupt event.

Pin inputs are brought into the clock domain by two flops. Edges are found by comparing the synchronized level with its value one cycle earlier. An event latches a per-bank pending bit, which software clears by writing a one to it. Per-bank mask bytes decide which pending bits reach the single interrupt line. One further address holds a free 8-bit panel-control byte with no interrupt logic attached.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset all pin control registers read 0, so every pin is an input with interrupts off. Both mask bytes read 0xFF, both pending bytes read 0x00, the panel byte reads 0x00, pad_oe is all zeros and irq_out is low.
- R2: The output-control register of pin p sits at 0x2B+p for p in 0..7 and at 0x3B+(p-8) for p in 8..15. It stores bits 5:0 of the written byte and reads back bits 7:6 as 0. Its fields are: bit 5 direction (1 = output), bit 4 open-drain, bit 3 pull enable, bits 2:1 pull select, bit 0 output value.
- R3: When bit 5 is 1 and bit 4 is 0, pad_oe[p] is 1 and pad_out[p] equals bit 0. When bit 5 is 1 and bit 4 is 1, pad_out[p] is 0 and pad_oe[p] is 1 only while bit 0 is 0. When bit 5 is 0, pad_oe[p] is 0.
- R4: The input-control register of pin p sits at 0x33+p for bank 0 and at 0x43+(p-8) for bank 1. Bit 0 reads the level of pad_in[p], which becomes visible after the second rising clock edge following the change. Bits 2:1 hold the written edge code, and bits 7:3 read 0.
- R5: Edge code 0 detects nothing, 1 detects falling edges, 2 detects rising edges and 3 detects both. A detected edge of pin p sets bit p mod 8 of the pending byte at 0x0B (bank 0) or 0x0C (bank 1), on the third rising edge after pad_in changes.
- R6: Writing a byte to a pending address clears exactly the bits written as 1. Bits written as 0 keep their value. If an edge is detected in the same cycle as a clear of that bit, the bit stays set.
- R7: The mask bytes are at 0x19 (bank 0) and 0x1A (bank 1) and are fully writable. A mask bit of 1 blocks that pin's interrupt and 0 allows it. Pending bits are set whatever the mask holds.
- R8: irq_out is high exactly when some pin has both its pending bit at 1 and its mask bit at 0.
- R9: Address 0x52 is an 8-bit read/write panel byte. Writing it does not alter any pending bit, mask bit or irq_out.
- R10: Reads of any unmapped address return 0. Writes to unmapped addresses change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, valid in the strobe cycle, 0 otherwise |
| pad_in | input | 16 | Asynchronous pin levels |
| pad_out | output | 16 | Driven pin levels |
| pad_oe | output | 16 | Per-pin drive enable |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The properties assume that writes and reads are single-cycle strobes with a stable address, and that a pending-bit clear is checked only on cycles when that pin's edge code is 0, since an edge may legally win against the clear. The stimulus changes pad_in only just after a clock edge and waits at least three edges before it reads a pending or level bit. It never asserts both strobes at once. The coincident edge-and-clear case is placed on purpose so that the write lands on the edge that latches the event.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int BANKS         = 2;
    localparam int PINS_PER_BANK = 8;
    localparam int PINS          = BANKS * PINS_PER_BANK;
    localparam int PIN_W         = $clog2(PINS);
    localparam int BANK_W        = (BANKS > 1) ? $clog2(BANKS) : 1;
    localparam int DW            = 8;
    localparam int AW            = 8;

    localparam logic [AW-1:0] PEND_BASE  = 8'h0B;
    localparam logic [AW-1:0] MASK_BASE  = 8'h19;
    localparam logic [AW-1:0] OUT_BASE0  = 8'h2B;
    localparam logic [AW-1:0] OUT_BASE1  = 8'h3B;
    localparam logic [AW-1:0] IN_BASE0   = 8'h33;
    localparam logic [AW-1:0] IN_BASE1   = 8'h43;
    localparam logic [AW-1:0] PANEL_ADDR = 8'h52;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_FALL = 2'd1,
        EDGE_RISE = 2'd2,
        EDGE_BOTH = 2'd3
    } edge_sel_e;

    typedef struct packed {
        logic       dir;
        logic       odrain;
        logic       pull_en;
        logic [1:0] pull_sel;
        logic       level;
    } outctl_t;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_OUTCTL,
        REG_INCTL,
        REG_PEND,
        REG_MASK,
        REG_PANEL
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e         kind;
        logic [BANK_W-1:0] bank;
        logic [PIN_W-1:0]  pin;
    } reg_sel_t;

    function automatic logic [AW-1:0] out_base(int b);
        return (b == 0) ? OUT_BASE0 : OUT_BASE1;
    endfunction

    function automatic logic [AW-1:0] in_base(int b);
        return (b == 0) ? IN_BASE0 : IN_BASE1;
    endfunction

    function automatic reg_sel_t decode_addr(logic [AW-1:0] a);
        reg_sel_t    s;
        logic [AW-1:0] d;
        s.kind = REG_NONE;
        s.bank = '0;
        s.pin  = '0;
        for (int b = 0; b < BANKS; b++) begin
            d = a - out_base(b);
            if (d < AW'(PINS_PER_BANK)) begin
                s.kind = REG_OUTCTL;
                s.bank = BANK_W'(b);
                s.pin  = PIN_W'(b * PINS_PER_BANK) + PIN_W'(d);
            end
            d = a - in_base(b);
            if (d < AW'(PINS_PER_BANK)) begin
                s.kind = REG_INCTL;
                s.bank = BANK_W'(b);
                s.pin  = PIN_W'(b * PINS_PER_BANK) + PIN_W'(d);
            end
            if (a == PEND_BASE + AW'(b)) begin
                s.kind = REG_PEND;
                s.bank = BANK_W'(b);
            end
            if (a == MASK_BASE + AW'(b)) begin
                s.kind = REG_MASK;
                s.bank = BANK_W'(b);
            end
        end
        if (a == PANEL_ADDR) s.kind = REG_PANEL;
        return s;
    endfunction

    function automatic logic edge_hit(edge_sel_e sel, logic cur, logic prev);
        logic rise;
        logic fall;
        rise = cur & ~prev;
        fall = ~cur & prev;
        case (sel)
            EDGE_FALL: return fall;
            EDGE_RISE: return rise;
            EDGE_BOTH: return rise | fall;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync
    import gpio_bank_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      pad_in,
    input  edge_sel_e sense,
    output logic      level,
    output logic      event_hit
);
    logic meta_q;
    logic sync_q;
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= pad_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign level     = sync_q;
    assign event_hit = edge_hit(sense, sync_q, prev_q);
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive (
    input  logic dir,
    input  logic odrain,
    input  logic level,
    output logic pad_out,
    output logic pad_oe
);
    always_comb begin
        if (odrain) begin
            pad_out = 1'b0;
            pad_oe  = dir & ~level;
        end else begin
            pad_out = level;
            pad_oe  = dir;
        end
    end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_bank_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic [PINS_PER_BANK-1:0] events,
    input  logic                     pend_wr,
    input  logic                     mask_wr,
    input  logic [DW-1:0]            wdata,
    output logic [PINS_PER_BANK-1:0] pend,
    output logic [PINS_PER_BANK-1:0] mask,
    output logic                     irq
);
    logic [PINS_PER_BANK-1:0] clr;

    assign clr = pend_wr ? wdata[PINS_PER_BANK-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
            mask <= '1;
        end else begin
            pend <= (pend & ~clr) | events;
            if (mask_wr) mask <= wdata[PINS_PER_BANK-1:0];
        end
    end

    assign irq = |(pend & ~mask);
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    input  logic            bus_wr,
    input  logic            bus_rd,
    output logic [DW-1:0]   bus_rdata,
    input  logic [PINS-1:0] pad_in,
    output logic [PINS-1:0] pad_out,
    output logic [PINS-1:0] pad_oe,
    output logic            irq_out
);
    localparam int OCW = $bits(outctl_t);

    reg_sel_t         sel;
    outctl_t          octl  [PINS];
    edge_sel_e        sense [PINS];
    logic [DW-1:0]    panel;
    logic [PINS-1:0]  lvl;
    logic [PINS-1:0]  evt;
    logic [PINS-1:0]  pend_all;
    logic [PINS-1:0]  mask_all;
    logic [BANKS-1:0] bank_irq;
    logic [PINS-1:0]  dir_v;
    logic [PINS-1:0]  od_v;
    logic [PINS-1:0]  val_v;
    logic [2*PINS-1:0] sense_v;
    logic [DW-1:0]    rd_mux;

    assign sel = decode_addr(bus_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < PINS; i++) begin
                octl[i]  <= '0;
                sense[i] <= EDGE_NONE;
            end
            panel <= '0;
        end else if (bus_wr) begin
            case (sel.kind)
                REG_OUTCTL: octl[sel.pin]  <= outctl_t'(bus_wdata[OCW-1:0]);
                REG_INCTL:  sense[sel.pin] <= edge_sel_e'(bus_wdata[2:1]);
                REG_PANEL:  panel          <= bus_wdata;
                default: ;
            endcase
        end
    end

    for (genvar p = 0; p < PINS; p++) begin : g_pin
        gpio_pin_sync u_sync (
            .clk       (clk),
            .rst       (rst),
            .pad_in    (pad_in[p]),
            .sense     (sense[p]),
            .level     (lvl[p]),
            .event_hit (evt[p])
        );
        gpio_pad_drive u_drv (
            .dir     (octl[p].dir),
            .odrain  (octl[p].odrain),
            .level   (octl[p].level),
            .pad_out (pad_out[p]),
            .pad_oe  (pad_oe[p])
        );
        assign dir_v[p]          = octl[p].dir;
        assign od_v[p]           = octl[p].odrain;
        assign val_v[p]          = octl[p].level;
        assign sense_v[2*p +: 2] = sense[p];
    end

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic pend_wr_b;
        logic mask_wr_b;
        assign pend_wr_b = bus_wr && (sel.kind == REG_PEND) && (sel.bank == BANK_W'(b));
        assign mask_wr_b = bus_wr && (sel.kind == REG_MASK) && (sel.bank == BANK_W'(b));
        gpio_irq_bank u_bank (
            .clk     (clk),
            .rst     (rst),
            .events  (evt[b*PINS_PER_BANK +: PINS_PER_BANK]),
            .pend_wr (pend_wr_b),
            .mask_wr (mask_wr_b),
            .wdata   (bus_wdata),
            .pend    (pend_all[b*PINS_PER_BANK +: PINS_PER_BANK]),
            .mask    (mask_all[b*PINS_PER_BANK +: PINS_PER_BANK]),
            .irq     (bank_irq[b])
        );
    end

    assign irq_out = |bank_irq;

    always_comb begin
        rd_mux = '0;
        case (sel.kind)
            REG_OUTCTL: rd_mux = DW'(octl[sel.pin]);
            REG_INCTL:  rd_mux = DW'({sense[sel.pin], lvl[sel.pin]});
            REG_PEND:   rd_mux = DW'(pend_all[sel.bank*PINS_PER_BANK +: PINS_PER_BANK]);
            REG_MASK:   rd_mux = DW'(mask_all[sel.bank*PINS_PER_BANK +: PINS_PER_BANK]);
            REG_PANEL:  rd_mux = panel;
            default:    rd_mux = '0;
        endcase
    end

    assign bus_rdata = bus_rd ? rd_mux : '0;
endmodule

// File: rtl/gpio_bank_ctrl_chk.sv
module gpio_bank_ctrl_chk
    import gpio_bank_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [AW-1:0]     bus_addr,
    input logic [DW-1:0]     bus_wdata,
    input logic              bus_wr,
    input logic [PINS-1:0]   pend_v,
    input logic [PINS-1:0]   mask_v,
    input logic [2*PINS-1:0] sense_v,
    input logic [PINS-1:0]   dir_v,
    input logic [PINS-1:0]   od_v,
    input logic [PINS-1:0]   val_v,
    input logic [PINS-1:0]   pad_oe,
    input logic              irq_out
);
    p_mask_blocks_r7: assert property (@(posedge clk) disable iff (rst)
        (&mask_v) |-> !irq_out);

    for (genvar i = 0; i < PINS; i++) begin : g_chk
        localparam logic [AW-1:0] PADDR = PEND_BASE + AW'(i / PINS_PER_BANK);

        p_edge_needs_sense_r5: assert property (@(posedge clk) disable iff (rst)
            $rose(pend_v[i]) |-> ($past(sense_v[2*i +: 2]) != 2'd0));

        p_w1c_clears_r6: assert property (@(posedge clk) disable iff (rst)
            (bus_wr && bus_addr == PADDR && bus_wdata[i % PINS_PER_BANK]
             && sense_v[2*i +: 2] == 2'd0) |=> !pend_v[i]);

        p_od_release_r3: assert property (@(posedge clk) disable iff (rst)
            (dir_v[i] && od_v[i] && val_v[i]) |-> !pad_oe[i]);

        p_input_float_r3: assert property (@(posedge clk) disable iff (rst)
            !dir_v[i] |-> !pad_oe[i]);
    end
endmodule

bind gpio_bank_ctrl gpio_bank_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .pend_v    (pend_all),
    .mask_v    (mask_all),
    .sense_v   (sense_v),
    .dir_v     (dir_v),
    .od_v      (od_v),
    .val_v     (val_v),
    .pad_oe    (pad_oe),
    .irq_out   (irq_out)
);

// File: tb/gpio_bank_ctrl_tb_top.sv
module gpio_bank_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic [15:0] pad_in = '0;
    logic [15:0] pad_out;
    logic [15:0] pad_oe;
    logic        irq_out;

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct {
        logic [7:0] addr;
        logic [7:0] exp;
        string      tag;
    } rd_item_t;

    rd_item_t sb_q[$];

    gpio_bank_ctrl dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .irq_out   (irq_out)
    );

    always #5 clk = ~clk;

    // monitor: pops expected read items and compares the returned byte
    always @(negedge clk) begin
        if (bus_rd) begin
            rd_item_t it;
            n_cmp++;
            if (sb_q.size() == 0) begin
                n_bad++;
                $display("FAIL %s: read without expected item at addr %02h", "scoreboard", bus_addr);
            end else begin
                it = sb_q.pop_front();
                if (bus_rdata !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: addr %02h actual %02h expected %02h",
                             it.tag, it.addr, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        #1;
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
        rd_item_t it;
        it.addr = a;
        it.exp  = e;
        it.tag  = tag;
        sb_q.push_back(it);
        bus_addr = a;
        bus_rd   = 1'b1;
        @(posedge clk);
        #1;
        bus_rd   = 1'b0;
    endtask

    task automatic chk(input logic [15:0] act, input logic [15:0] e, input string tag);
        n_cmp++;
        if (act !== e) begin
            n_bad++;
            $display("FAIL %s: actual %04h expected %04h", tag, act, e);
        end
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        tick(4);
        rst = 1'b0;
        tick(1);

        // R1 reset state
        rd(8'h19, 8'hFF, "R1 mask0");
        rd(8'h1A, 8'hFF, "R1 mask1");
        rd(8'h0B, 8'h00, "R1 pend0");
        rd(8'h0C, 8'h00, "R1 pend1");
        rd(8'h2B, 8'h00, "R1 outctl0");
        rd(8'h43, 8'h00, "R1 inctl8");
        rd(8'h52, 8'h00, "R1 panel");
        chk(pad_oe, 16'h0000, "R1 pad_oe");
        chk({15'b0, irq_out}, 16'h0000, "R1 irq");

        // R2 / R3 output-control and pad drive
        wr(8'h2B, 8'hFF);
        rd(8'h2B, 8'h3F, "R2 outctl0 readback");
        chk({15'b0, pad_oe[0]}, 16'h0000, "R3 od high released");
        chk({15'b0, pad_out[0]}, 16'h0000, "R3 od drives low level");
        wr(8'h2B, 8'h21);
        chk({14'b0, pad_oe[0], pad_out[0]}, 16'h0003, "R3 cmos high");
        wr(8'h2B, 8'h30);
        chk({14'b0, pad_oe[0], pad_out[0]}, 16'h0002, "R3 od low driven");
        wr(8'h3D, 8'h0A);
        rd(8'h3D, 8'h0A, "R2 outctl10 input set");
        chk({15'b0, pad_oe[10]}, 16'h0000, "R3 input not driven");
        wr(8'h42, 8'h20);
        chk({14'b0, pad_oe[15], pad_out[15]}, 16'h0002, "R2 pin15 address");

        // R4 level readback and edge code storage
        pad_in[3] = 1'b1;
        tick(3);
        rd(8'h36, 8'h01, "R4 level pin3");
        rd(8'h0B, 8'h00, "R5 code none ignores edge");
        wr(8'h36, 8'hFF);
        rd(8'h36, 8'h07, "R4 code both plus level");

        // R5 rising on pin 9
        wr(8'h44, 8'h04);
        pad_in[9] = 1'b1;
        tick(3);
        rd(8'h0C, 8'h02, "R5 rising pin9");
        wr(8'h0C, 8'h02);
        rd(8'h0C, 8'h00, "R6 clear pin9");
        pad_in[9] = 1'b0;
        tick(3);
        rd(8'h0C, 8'h00, "R5 rising ignores fall");

        // R5 falling on pin 4
        wr(8'h37, 8'h02);
        pad_in[4] = 1'b1;
        tick(3);
        rd(8'h0B, 8'h00, "R5 falling ignores rise");
        pad_in[4] = 1'b0;
        tick(3);
        rd(8'h0B, 8'h10, "R5 falling pin4");
        pad_in[3] = 1'b0;
        tick(3);
        rd(8'h0B, 8'h18, "R5 both pin3 fall");

        // R7 / R8 masking
        chk({15'b0, irq_out}, 16'h0000, "R7 masked pending no irq");
        wr(8'h19, 8'hEF);
        chk({15'b0, irq_out}, 16'h0001, "R8 unmasked pin4 irq");
        rd(8'h19, 8'hEF, "R7 mask0 readback");

        // R6 write-one-to-clear
        wr(8'h0B, 8'h00);
        rd(8'h0B, 8'h18, "R6 zero write keeps");
        wr(8'h0B, 8'h10);
        rd(8'h0B, 8'h08, "R6 clear pin4 only");
        chk({15'b0, irq_out}, 16'h0000, "R8 remaining bit masked");

        // R6 edge coincident with clear
        pad_in[3] = 1'b1;
        @(posedge clk);
        @(posedge clk);
        #1;
        wr(8'h0B, 8'h08);
        rd(8'h0B, 8'h08, "R6 edge wins over clear");
        wr(8'h0B, 8'h08);
        rd(8'h0B, 8'h00, "R6 later clear");

        // R9 panel byte
        wr(8'h1A, 8'h00);
        wr(8'h52, 8'hA5);
        rd(8'h52, 8'hA5, "R9 panel readback");
        rd(8'h0C, 8'h00, "R9 panel no pending");
        chk({15'b0, irq_out}, 16'h0000, "R9 panel no irq");

        // R10 unmapped space
        wr(8'h00, 8'hFF);
        wr(8'h4B, 8'hFF);
        rd(8'h00, 8'h00, "R10 unmapped 00");
        rd(8'h4B, 8'h00, "R10 unmapped 4B");
        rd(8'h53, 8'h00, "R10 unmapped 53");
        rd(8'h1A, 8'h00, "R10 mask1 untouched");
        rd(8'h2B, 8'h30, "R10 outctl0 untouched");

        tick(2);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule